// File: doc/BRIEF.md
# Integer Divide and Square-Root Coprocessor

This block is a register-mapped arithmetic helper that a processor drives over a simple word-addressed bus. Software loads operands into registers. It then obtains a 32-bit signed or unsigned division, or a 32-bit unsigned square root, from a result register. Each operation runs for several clock cycles. Division resolves one quotient bit per cycle and takes 32 cycles. Square root resolves one root bit per cycle and takes 16 cycles.

A configuration register sets four things: signed or unsigned division, whether the result register shows the quotient or the remainder, whether a zero divisor makes result reads fail on the bus, and how a division is launched. In the default mode, writing the divisor launches the division. In the alternative mode, it is launched by a control write that carries a launch bit. Writing the radicand always launches a square root. A three-bit status code reports whether the unit is busy and which operation ran last. A result read issued during an operation is stalled by holding the ready line low.

The bus uses word addresses: 0 control, 1 dividend, 2 divisor, 3 radicand, 4 result. Any other address reads as zero. A transfer completes in the cycle where `bus_sel` and `bus_ready` are both high. Writes always complete at once.

The control register fields are:

- bit 0: unsigned mode. 1 gives an unsigned division, 0 a signed one.
- bit 1: remainder select. 1 makes the result register show the remainder.
- bit 2: zero-divide error enable.
- bit 3: fast-start off.
- bit 4: launch bit. It is write-only and always reads as 0.
- bit 5: zero-divide flag. It is read-only.
- bits 10:8: status code, read-only. Bit 10 is busy, bit 9 means the last operation was a division, bit 8 means it was a square root.

Top module: `arith_cop`

## Requirements
- R1: An unsigned division (control bit 0 = 1) with a nonzero divisor yields floor(a/b) as quotient and a mod b as remainder. Control bit 1 picks which one the result register (address 4) returns at read time.
- R2: A signed division (control bit 0 = 0) truncates toward zero, and the remainder takes the dividend's sign. The case 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R3: Writing the radicand (address 3) computes the 16-bit floor square root, which reads back zero-extended from address 4.
- R4: A result read issued in the cycle after a launching write sees `bus_ready` low for exactly 32 cycles for a division and 16 cycles for a square root. The read then returns the result.
- R5: The status code in control bits 10:8 reads 0 after reset, 6 while a division runs, 5 while a square root runs, 2 when idle after a division and 1 when idle after a square root.
- R6: With control bit 3 = 0, a divisor write (address 2) launches a division with the stored dividend and the written divisor.
- R7: With control bit 3 = 1, a divisor write only stores the value. A control write with bits 3 and 4 both set launches the division. Bit 4 always reads back as 0.
- R8: A division with a zero divisor completes without busy time and sets control bit 5. The quotient then reads as 0xFFFFFFFF and the remainder reads as the dividend. The flag clears when the next operation launches.
- R9: A read of address 4 while control bits 5 and 2 are both set completes with `bus_err` high. Otherwise `bus_err` stays low and the data is returned.
- R10: Any register write issued while the unit is busy is ignored. This includes an operand write that would otherwise launch an operation.
- R11: After reset, every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bus_sel | input | 1 | Transfer request, held until `bus_ready` is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when `bus_ready` is high |
| bus_ready | output | 1 | Transfer completes this cycle |
| bus_err | output | 1 | The completing read is error-terminated |

## Verification
Random unsigned and signed operand pairs exercise the restoring divider. They include small and negative divisors, and for each pair both the quotient and the remainder view are read. This separates errors in the magnitude loop from errors in the sign fix-up. Directed cases cover the most negative dividend over -1, a zero divisor with the error enable on and off, and the control-bit launch mode, where a bare divisor write must not start anything. Random radicands plus 0, 1, perfect squares and the all-ones value test the root loop's boundaries. Stall counts on result reads, and status reads taken during an operation, separate the 32-cycle and 16-cycle timing and the busy code from the idle code.

// File: rtl/arith_cop_pkg.sv
package arith_cop_pkg;
  // register word addresses
  localparam int REG_CTRL = 0;
  localparam int REG_DEND = 1;
  localparam int REG_DSOR = 2;
  localparam int REG_RAD  = 3;
  localparam int REG_RES  = 4;
  // control register bit positions
  localparam int BIT_UNS   = 0;
  localparam int BIT_REM   = 1;
  localparam int BIT_DZE   = 2;
  localparam int BIT_FSO   = 3;
  localparam int BIT_START = 4;
  localparam int BIT_DZ    = 5;
  localparam int BIT_CODE  = 8;
  // last-operation encoding, forms status code bits 1:0
  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_SQRT = 2'd1;
  localparam logic [1:0] OP_DIV  = 2'd2;
endpackage

// File: rtl/cop_divider.sv
module cop_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         uns,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  acc_q, acc_n, quo_q, quo_n, dsr_q, dsr_n;
  logic          negq_q, negq_n, negr_q, negr_n;
  logic          a_neg, b_neg;
  logic [W-1:0]  a_mag, b_mag;
  logic [W:0]    shifted, diff;

  always_comb begin
    a_neg   = !uns && dividend[W-1];
    b_neg   = !uns && divisor[W-1];
    a_mag   = a_neg ? (~dividend + W'(1)) : dividend;
    b_mag   = b_neg ? (~divisor + W'(1)) : divisor;
    shifted = {acc_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dsr_q};
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    quo_n   = quo_q;
    dsr_n   = dsr_q;
    negq_n  = negq_q;
    negr_n  = negr_q;
    if (start) begin
      cnt_n  = CW'(W);
      acc_n  = '0;
      quo_n  = a_mag;
      dsr_n  = b_mag;
      negq_n = a_neg ^ b_neg;
      negr_n = a_neg;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CW'(1);
      if (!diff[W]) begin
        acc_n = diff[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b1};
      end else begin
        acc_n = shifted[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
      quo_q  <= quo_n;
      dsr_q  <= dsr_n;
      negq_q <= negq_n;
      negr_q <= negr_n;
    end
  end

  assign busy = (cnt_q != '0);
  assign quot = negq_q ? (~quo_q + W'(1)) : quo_q;
  assign rem  = negr_q ? (~acc_q + W'(1)) : acc_q;
endmodule

// File: rtl/cop_sqrt.sv
module cop_sqrt #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   radicand,
  output logic           busy,
  output logic [W/2-1:0] root
);
  localparam int RW = W / 2;
  localparam int CW = $clog2(RW + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  x_q, x_n;
  logic [RW+1:0] rem_q, rem_n, shifted, trial;
  logic [RW-1:0] root_q, root_n;
  logic [RW+2:0] diff;

  always_comb begin
    shifted = {rem_q[RW-1:0], x_q[W-1:W-2]};
    trial   = {root_q, 2'b01};
    diff    = {1'b0, shifted} - {1'b0, trial};
    cnt_n   = cnt_q;
    x_n     = x_q;
    rem_n   = rem_q;
    root_n  = root_q;
    if (start) begin
      cnt_n  = CW'(RW);
      x_n    = radicand;
      rem_n  = '0;
      root_n = '0;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CW'(1);
      x_n   = {x_q[W-3:0], 2'b00};
      if (!diff[RW+2]) begin
        rem_n  = diff[RW+1:0];
        root_n = {root_q[RW-2:0], 1'b1};
      end else begin
        rem_n  = shifted;
        root_n = {root_q[RW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      x_q    <= '0;
      rem_q  <= '0;
      root_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      x_q    <= x_n;
      rem_q  <= rem_n;
      root_q <= root_n;
    end
  end

  assign busy = (cnt_q != '0);
  assign root = root_q;
endmodule

// File: rtl/arith_cop.sv
module arith_cop
  import arith_cop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_err
);
  localparam int ROOT_W = DATA_W / 2;

  logic              cfg_uns_q, cfg_rem_q, cfg_dze_q, cfg_fso_q, dz_flag_q;
  logic              cfg_uns_n, cfg_rem_n, cfg_dze_n, cfg_fso_n, dz_flag_n;
  logic [1:0]        last_op_q, last_op_n;
  logic [DATA_W-1:0] dend_q, dend_n, dsor_q, dsor_n, rad_q, rad_n, dzr_q, dzr_n;

  logic              div_busy, sqrt_busy, busy;
  logic              wr_ok, wr_ctrl, wr_dend, wr_dsor, wr_rad, rd_res;
  logic              div_req, div_zero, div_start, sqrt_start, div_uns;
  logic [DATA_W-1:0] div_b, core_quo, core_rem, res_val, ctrl_val;
  logic [ROOT_W-1:0] core_root;

  assign busy    = div_busy || sqrt_busy;
  assign wr_ok   = bus_sel && bus_wr && !busy;
  assign wr_ctrl = wr_ok && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_dend = wr_ok && (bus_addr == ADDR_W'(REG_DEND));
  assign wr_dsor = wr_ok && (bus_addr == ADDR_W'(REG_DSOR));
  assign wr_rad  = wr_ok && (bus_addr == ADDR_W'(REG_RAD));
  assign rd_res  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(REG_RES));

  // launch decode
  assign div_req    = (wr_dsor && !cfg_fso_q) ||
                      (wr_ctrl && bus_wdata[BIT_FSO] && bus_wdata[BIT_START]);
  assign div_b      = wr_dsor ? bus_wdata : dsor_q;
  assign div_zero   = (div_b == '0);
  assign div_start  = div_req && !div_zero;
  assign sqrt_start = wr_rad;
  assign div_uns    = wr_ctrl ? bus_wdata[BIT_UNS] : cfg_uns_q;

  cop_divider #(.W(DATA_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .uns      (div_uns),
    .dividend (dend_q),
    .divisor  (div_b),
    .busy     (div_busy),
    .quot     (core_quo),
    .rem      (core_rem)
  );

  cop_sqrt #(.W(DATA_W)) u_sqrt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sqrt_start),
    .radicand (bus_wdata),
    .busy     (sqrt_busy),
    .root     (core_root)
  );

  // next-state logic
  always_comb begin
    cfg_uns_n = cfg_uns_q;
    cfg_rem_n = cfg_rem_q;
    cfg_dze_n = cfg_dze_q;
    cfg_fso_n = cfg_fso_q;
    dz_flag_n = dz_flag_q;
    last_op_n = last_op_q;
    dend_n    = dend_q;
    dsor_n    = dsor_q;
    rad_n     = rad_q;
    dzr_n     = dzr_q;
    if (wr_ctrl) begin
      cfg_uns_n = bus_wdata[BIT_UNS];
      cfg_rem_n = bus_wdata[BIT_REM];
      cfg_dze_n = bus_wdata[BIT_DZE];
      cfg_fso_n = bus_wdata[BIT_FSO];
    end
    if (wr_dend) dend_n = bus_wdata;
    if (wr_dsor) dsor_n = bus_wdata;
    if (wr_rad)  rad_n  = bus_wdata;
    if (div_req) begin
      last_op_n = OP_DIV;
      dz_flag_n = div_zero;
      if (div_zero) dzr_n = dend_q;
    end
    if (sqrt_start) begin
      last_op_n = OP_SQRT;
      dz_flag_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_uns_q <= 1'b0;
      cfg_rem_q <= 1'b0;
      cfg_dze_q <= 1'b0;
      cfg_fso_q <= 1'b0;
      dz_flag_q <= 1'b0;
      last_op_q <= OP_NONE;
      dend_q    <= '0;
      dsor_q    <= '0;
      rad_q     <= '0;
      dzr_q     <= '0;
    end else if (wr_ok) begin
      cfg_uns_q <= cfg_uns_n;
      cfg_rem_q <= cfg_rem_n;
      cfg_dze_q <= cfg_dze_n;
      cfg_fso_q <= cfg_fso_n;
      dz_flag_q <= dz_flag_n;
      last_op_q <= last_op_n;
      dend_q    <= dend_n;
      dsor_q    <= dsor_n;
      rad_q     <= rad_n;
      dzr_q     <= dzr_n;
    end
  end

  // read path
  always_comb begin
    ctrl_val = '0;
    ctrl_val[BIT_UNS] = cfg_uns_q;
    ctrl_val[BIT_REM] = cfg_rem_q;
    ctrl_val[BIT_DZE] = cfg_dze_q;
    ctrl_val[BIT_FSO] = cfg_fso_q;
    ctrl_val[BIT_DZ]  = dz_flag_q;
    ctrl_val[BIT_CODE+2:BIT_CODE] = {busy, last_op_q};
    case (last_op_q)
      OP_SQRT: res_val = DATA_W'(core_root);
      OP_DIV:  res_val = dz_flag_q ? (cfg_rem_q ? dzr_q : '1)
                                   : (cfg_rem_q ? core_rem : core_quo);
      default: res_val = '0;
    endcase
    case (bus_addr)
      ADDR_W'(REG_CTRL): bus_rdata = ctrl_val;
      ADDR_W'(REG_DEND): bus_rdata = dend_q;
      ADDR_W'(REG_DSOR): bus_rdata = dsor_q;
      ADDR_W'(REG_RAD):  bus_rdata = rad_q;
      ADDR_W'(REG_RES):  bus_rdata = res_val;
      default:           bus_rdata = '0;
    endcase
  end

  assign bus_ready = !(rd_res && busy);
  assign bus_err   = rd_res && !busy && dz_flag_q && cfg_dze_q;
endmodule

// File: rtl/arith_cop_chk.sv
module arith_cop_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_ready,
  input logic              bus_err,
  input logic              div_busy,
  input logic              sqrt_busy,
  input logic              div_start,
  input logic              sqrt_start,
  input logic              dz_flag,
  input logic [1:0]        last_op,
  input logic [DATA_W-1:0] dend,
  input logic [DATA_W-1:0] dsor,
  input logic [DATA_W-1:0] rad
);
  assert_div_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> div_busy);

  assert_sqrt_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sqrt_start |=> sqrt_busy);

  assert_one_engine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_busy && sqrt_busy));

  assert_stall_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> (bus_sel && !bus_wr && (div_busy || sqrt_busy)));

  assert_err_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_ready && bus_sel && !bus_wr && dz_flag));

  assert_flag_after_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dz_flag |-> (last_op == 2'd2));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy || sqrt_busy) |=> ($stable(dend) && $stable(dsor) && $stable(rad)
                                 && $stable(last_op)));
endmodule

bind arith_cop arith_cop_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_ready  (bus_ready),
  .bus_err    (bus_err),
  .div_busy   (div_busy),
  .sqrt_busy  (sqrt_busy),
  .div_start  (div_start),
  .sqrt_start (sqrt_start),
  .dz_flag    (dz_flag_q),
  .last_op    (last_op_q),
  .dend       (dend_q),
  .dsor       (dsor_q),
  .rad        (rad_q)
);

// File: tb/test_arith_cop.sv
module test_arith_cop;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, sel, wr, ready, err;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  int checks = 0;
  int errors = 0;

  arith_cop i_arith_cop (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready), .bus_err(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic bus_write(input int a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d, output logic e, output int stall);
    sel = 1'b1; wr = 1'b0; addr = 3'(a); stall = 0;
    #1;
    while (!ready) begin
      stall++;
      @(negedge clk); #1;
    end
    d = rdata; e = err;
    @(negedge clk);
    sel = 1'b0;
  endtask

  function automatic logic [31:0] ref_q(input logic [31:0] a, input logic [31:0] b, input bit uns);
    if (b == 0) return 32'hFFFF_FFFF;
    if (uns) return a / b;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
    return 32'($signed(a) / $signed(b));
  endfunction

  function automatic logic [31:0] ref_r(input logic [31:0] a, input logic [31:0] b, input bit uns);
    if (b == 0) return a;
    if (uns) return a % b;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 0;
    return 32'($signed(a) % $signed(b));
  endfunction

  function automatic logic [31:0] ref_sqrt(input logic [31:0] x);
    logic [63:0] r = 0;
    for (int k = 15; k >= 0; k--) begin
      logic [63:0] t = r | (64'd1 << k);
      if (t * t <= {32'd0, x}) r = t;
    end
    return r[31:0];
  endfunction

  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input bit uns);
    logic [31:0] d; logic e; int st;
    string tag = (b == 0) ? "R8" : (uns ? "R1" : "R2");
    bus_write(0, {30'd0, 1'b0, uns});
    bus_write(1, a);
    bus_write(2, b);
    bus_read(4, d, e, st);
    check({tag, " quotient"}, d, ref_q(a, b, uns));
    check("R4 divide stall", st, (b == 0) ? 0 : 32);
    bus_write(0, {30'd0, 1'b1, uns});
    bus_read(4, d, e, st);
    check({tag, " remainder"}, d, ref_r(a, b, uns));
  endtask

  task automatic run_sqrt(input logic [31:0] x);
    logic [31:0] d; logic e; int st;
    bus_write(3, x);
    bus_read(4, d, e, st);
    check("R3 root", d, ref_sqrt(x));
    check("R4 root stall", st, 16);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, a, b; logic e; int st;
    void'($urandom(32'd2024));
    sel = 0; wr = 0; addr = 0; wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 / R5 reset state
    bus_read(0, d, e, st); check("R11 R5 control at reset", d, 0);
    bus_read(1, d, e, st); check("R11 dividend at reset", d, 0);
    bus_read(4, d, e, st); check("R11 result at reset", d, 0);

    // directed divide corners
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_div(32'hFFFF_FFF9, 32'd2, 0);
    run_div(32'd7, 32'hFFFF_FFFE, 0);
    run_div(32'hFFFF_FFFF, 32'd1, 1);
    run_div(32'd5, 32'd9, 1);
    // random divides
    for (int i = 0; i < 30; i++) begin
      a = $urandom; b = $urandom;
      if ($urandom % 3 == 0) b = $urandom % 16;
      if ($urandom % 4 == 0) b = -($urandom % 16);
      run_div(a, b, 1'($urandom % 2));
    end

    // R5 status during and after operations
    bus_write(0, 0);
    bus_write(1, 32'd1000);
    bus_write(2, 32'd10);
    bus_read(0, d, e, st); check("R5 busy divide code", d[10:8], 3'h6);
    // R10 writes while busy are ignored
    bus_write(1, 32'd5);
    bus_write(3, 32'd81);
    bus_read(4, d, e, st); check("R10 result unaffected", d, 32'd100);
    bus_read(1, d, e, st); check("R10 dividend kept", d, 32'd1000);
    bus_read(0, d, e, st); check("R5 idle divide code", d[10:8], 3'h2);
    bus_write(3, 32'd49);
    bus_read(0, d, e, st); check("R5 busy root code", d[10:8], 3'h5);
    bus_read(4, d, e, st); check("R3 root of 49", d, 32'd7);
    bus_read(0, d, e, st); check("R5 idle root code", d[10:8], 3'h1);

    // root corners and random
    run_sqrt(0); run_sqrt(1); run_sqrt(32'hFFFF_FFFF); run_sqrt(32'hFFFE_0001);
    for (int i = 0; i < 20; i++) run_sqrt($urandom);

    // R7 launch by control bit
    bus_write(0, 32'h8);
    bus_write(1, 32'd100);
    bus_write(2, 32'd7);
    bus_read(0, d, e, st); check("R7 divisor write does not launch", d[10:8], 3'h1);
    bus_write(0, 32'h18);
    bus_read(0, d, e, st);
    check("R7 control launch busy", d[10:8], 3'h6);
    check("R7 launch bit reads 0", d[4], 0);
    bus_read(4, d, e, st); check("R7 quotient", d, 32'd14);
    // R6 launch bit has no effect in fast mode
    bus_write(0, 32'h10);
    bus_read(0, d, e, st); check("R6 launch bit ignored in fast mode", d[10:8], 3'h2);

    // R8 / R9 zero divisor
    bus_write(0, 32'h4);
    bus_write(1, 32'd77);
    bus_write(2, 32'd0);
    bus_read(0, d, e, st);
    check("R8 flag set", d[5], 1);
    check("R8 no busy", d[10:8], 3'h2);
    bus_read(4, d, e, st); check("R9 error on result read", e, 1);
    bus_read(1, d, e, st); check("R9 no error on other read", e, 0);
    bus_write(0, 32'h0);
    bus_read(4, d, e, st);
    check("R9 no error when disabled", e, 0);
    check("R8 quotient all ones", d, 32'hFFFF_FFFF);
    bus_write(0, 32'h2);
    bus_read(4, d, e, st); check("R8 remainder is dividend", d, 32'd77);
    bus_write(3, 32'd16);
    bus_read(0, d, e, st); check("R8 flag cleared by next launch", d[5], 0);
    bus_read(4, d, e, st); check("R3 root of 16", d, 32'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule